// File: doc/BRIEF.md
# Peripheral Select Sequencer

This block sits between a host processor and up to four slave controllers. The host writes a control byte. Its low bits pick which slaves take part, the next bit sets the transfer direction, and the top field sets a power-of-two clock divider exponent. From that byte the block builds a periodic interrupt request toward the host. During the active half of each divided period it drives the enabled slave selects and the direction line toward the slaves.

Host data writes go out to every enabled slave, but only in write mode. Host data reads return the OR of the enabled slaves' data. A read-mode start clears the interrupt at once and skips the first interrupt pulse, which gives the slave time to place its data. A zero divider field stops the sequencer.

Top module: `periph_select_seq`

## Requirements
- R1: Control layout: bits [3:0] are per-slave enables, bit [4] is the direction (1 = read, 0 = write) and bits [7:5] hold the divider exponent n. A control read returns the last value written.
- R2: With n nonzero, the interrupt runs with a full period of 2^n clocks: high for 2^(n-1) clocks, then low for 2^(n-1) clocks.
- R3: After a control write with n nonzero, made while the next timer event is an active one, the first active phase begins one clock after the write edge.
- R4: Each slave select equals its enable bit during the active phase and is 0 during the inactive phase.
- R5: At the start of every active phase, the slave direction line takes the value of control bit 4.
- R6: A control write with bit 4 = 1 and n nonzero clears the interrupt on the write edge and suppresses the interrupt on the next timer event.
- R7: A control write with n = 0 stops the sequencer and clears the interrupt and all selects. The direction line keeps its value, and the next start begins with an active phase.
- R8: A control write with n nonzero, made while the last timer event was an active one, delays the first timer event by an extra 2^n clocks, so it falls 1 + 2^n clocks after the write edge.
- R9: A data write raises the write strobe of each enabled slave only while bit 4 of the held control value is 0. In the cycle of a simultaneous control write, the held (old) control value applies.
- R10: A data read returns the bitwise OR of the read data of all enabled slaves.
- R11: After reset the control register is 0, the interrupt and all selects are low, and the direction line is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control register write |
| ctrl_wdata | input | 8 | Control write value |
| ctrl_rdata | output | 8 | Control register readback |
| data_we | input | 1 | Host data write |
| data_wdata | input | 8 | Host data write value |
| data_rdata | output | 8 | OR of the enabled slaves' read data |
| slave_rdata | input | 32 | Read data from the slaves, slave i at bits [8i+7:8i] |
| slave_wdata | output | 8 | Write data toward the slaves |
| slave_wstrobe | output | 4 | Per-slave write strobe |
| slave_sel | output | 4 | Per-slave select |
| slave_rw | output | 1 | Direction toward the slaves (1 = read) |
| host_nmi | output | 1 | Periodic interrupt to the host |

## Verification
A control write can land in the same cycle as a pending timer event, or in the same cycle as a data write. The bench provokes the second case by raising both strobes on one clock. It expects the write strobes to follow the old control value in that cycle and the new value afterwards. The first case is provoked by restarting the sequencer while the interrupt is high. The bench judges it by the length of the extra delay and by when the suppressed pulse reappears, all computed from the divider exponent.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  // Half of one divided period, in input clocks (exponent n >= 1).
  function automatic int unsigned half_period(input int unsigned n);
    return (n == 0) ? 1 : (32'd1 << (n - 1));
  endfunction

  // One full divided period, in input clocks.
  function automatic int unsigned full_period(input int unsigned n);
    return 32'd1 << n;
  endfunction
endpackage

// File: rtl/pss_ctrl_reg.sv
`timescale 1ns/1ps
module pss_ctrl_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/pss_phase_timer.sv
`timescale 1ns/1ps
module pss_phase_timer
  import pss_pkg::*;
#(
  parameter int DIV_W = 3,
  localparam int CNT_W = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [DIV_W-1:0] div_w,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick,
  output logic             tick_active
);
  logic             running;
  logic             next_act;
  logic [CNT_W-1:0] cnt;

  assign tick        = running && (cnt == '0) && !ctrl_we;
  assign tick_active = next_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      next_act <= 1'b1;
      cnt      <= '0;
    end else if (ctrl_we) begin
      if (div_w == '0) begin
        running  <= 1'b0;
        next_act <= 1'b1;
        cnt      <= '0;
      end else begin
        running <= 1'b1;
        cnt     <= next_act ? '0 : CNT_W'(full_period(int'(div_w)));
      end
    end else if (tick) begin
      next_act <= !next_act;
      cnt      <= CNT_W'(half_period(int'(div_q)) - 1);
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: from an active-next state, the first event follows on the next edge
  a_r3_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && div_w != '0 && next_act) |=> (tick || ctrl_we));
  // R8: restart while the active phase is live is held off
  a_r8_extra_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && div_w != '0 && !next_act) |=> !tick);
endmodule

// File: rtl/pss_strobe_gen.sv
`timescale 1ns/1ps
module pss_strobe_gen #(
  parameter int NUM_SLAVES = 4,
  parameter int DIV_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [DIV_W-1:0]      div_w,
  input  logic                  dir_w,
  input  logic                  dir_q,
  input  logic [NUM_SLAVES-1:0] en_q,
  input  logic                  tick,
  input  logic                  tick_active,
  output logic                  nmi,
  output logic [NUM_SLAVES-1:0] sel,
  output logic                  rw
);
  logic skip_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi       <= 1'b0;
      sel       <= '0;
      rw        <= 1'b1;
      skip_next <= 1'b0;
    end else if (ctrl_we) begin
      if (div_w == '0) begin
        nmi       <= 1'b0;
        sel       <= '0;
        skip_next <= 1'b0;
      end else if (dir_w) begin
        nmi       <= 1'b0;
        skip_next <= 1'b1;
      end else begin
        skip_next <= 1'b0;
      end
    end else if (tick) begin
      if (tick_active) begin
        rw  <= dir_q;
        nmi <= !skip_next;
        sel <= en_q;
      end else begin
        nmi <= 1'b0;
        sel <= '0;
      end
      skip_next <= 1'b0;
    end
  end

  // R4: selects fall at every inactive event
  a_r4_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tick_active) |=> (sel == '0 && !nmi));
  // R5: direction follows the control bit at an active event
  a_r5_rw_update: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_active) |=> (rw == $past(dir_q)));
  // R6: read-mode start drops the interrupt on the write edge
  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && div_w != '0 && dir_w) |=> !nmi);
  // R7: halting clears the outputs but not the direction
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && div_w == '0) |=> (!nmi && sel == '0 && $stable(rw)));
endmodule

// File: rtl/pss_data_path.sv
`timescale 1ns/1ps
module pss_data_path #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8
) (
  input  logic                         data_we,
  input  logic [DATA_W-1:0]            data_wdata,
  input  logic                         dir_q,
  input  logic [NUM_SLAVES-1:0]        en_q,
  input  logic [NUM_SLAVES*DATA_W-1:0] slave_rdata,
  output logic [DATA_W-1:0]            data_rdata,
  output logic [DATA_W-1:0]            slave_wdata,
  output logic [NUM_SLAVES-1:0]        slave_wstrobe
);
  assign slave_wdata = data_wdata;

  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_wr
    assign slave_wstrobe[i] = data_we && !dir_q && en_q[i];
  end

  always_comb begin
    data_rdata = '0;
    for (int i = 0; i < NUM_SLAVES; i++)
      if (en_q[i]) data_rdata = data_rdata | slave_rdata[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/periph_select_seq.sv
`timescale 1ns/1ps
module periph_select_seq #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 3,
  localparam int CTRL_W    = NUM_SLAVES + 1 + DIV_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_we,
  input  logic [CTRL_W-1:0]            ctrl_wdata,
  output logic [CTRL_W-1:0]            ctrl_rdata,
  input  logic                         data_we,
  input  logic [DATA_W-1:0]            data_wdata,
  output logic [DATA_W-1:0]            data_rdata,
  input  logic [NUM_SLAVES*DATA_W-1:0] slave_rdata,
  output logic [DATA_W-1:0]            slave_wdata,
  output logic [NUM_SLAVES-1:0]        slave_wstrobe,
  output logic [NUM_SLAVES-1:0]        slave_sel,
  output logic                         slave_rw,
  output logic                         host_nmi
);
  localparam int DIR_BIT = NUM_SLAVES;

  logic [CTRL_W-1:0]     ctrl_q;
  logic [NUM_SLAVES-1:0] en_q;
  logic                  dir_q, dir_w;
  logic [DIV_W-1:0]      div_q, div_w;
  logic                  tick, tick_active;

  assign en_q       = ctrl_q[NUM_SLAVES-1:0];
  assign dir_q      = ctrl_q[DIR_BIT];
  assign div_q      = ctrl_q[CTRL_W-1 -: DIV_W];
  assign dir_w      = ctrl_wdata[DIR_BIT];
  assign div_w      = ctrl_wdata[CTRL_W-1 -: DIV_W];
  assign ctrl_rdata = ctrl_q;

  pss_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q));

  pss_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .div_w(div_w), .div_q(div_q),
    .tick(tick), .tick_active(tick_active));

  pss_strobe_gen #(.NUM_SLAVES(NUM_SLAVES), .DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .div_w(div_w), .dir_w(dir_w),
    .dir_q(dir_q), .en_q(en_q), .tick(tick), .tick_active(tick_active),
    .nmi(host_nmi), .sel(slave_sel), .rw(slave_rw));

  pss_data_path #(.NUM_SLAVES(NUM_SLAVES), .DATA_W(DATA_W)) u_data (
    .data_we(data_we), .data_wdata(data_wdata), .dir_q(dir_q), .en_q(en_q),
    .slave_rdata(slave_rdata), .data_rdata(data_rdata),
    .slave_wdata(slave_wdata), .slave_wstrobe(slave_wstrobe));

  // R11: reset leaves the outputs idle with the direction line at read
  a_r11_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!host_nmi && slave_sel == '0 && slave_rw && ctrl_q == '0));
endmodule

// File: tb/test_periph_select_seq.sv
`timescale 1ns/1ps
module test_periph_select_seq;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, data_we = 0;
  logic [7:0] ctrl_wdata = 0, data_wdata = 0;
  logic [7:0] ctrl_rdata, data_rdata, slave_wdata;
  logic [31:0] slave_rdata = 32'h8421_1248;
  logic [3:0] slave_wstrobe, slave_sel;
  logic slave_rw, host_nmi;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  periph_select_seq i_periph_select_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .slave_rdata(slave_rdata), .slave_wdata(slave_wdata),
    .slave_wstrobe(slave_wstrobe), .slave_sel(slave_sel), .slave_rw(slave_rw),
    .host_nmi(host_nmi));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // drive a control write; returns at 1 ns after the write edge
  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1; ctrl_we = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_nmi_high();
    for (int i = 0; i < 300 && !host_nmi; i++) step();
  endtask

  function automatic logic [7:0] or_sel(input logic [3:0] en);
    logic [7:0] r = 0;
    for (int i = 0; i < 4; i++) if (en[i]) r |= slave_rdata[8*i +: 8];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] ens [4] = '{4'b0001, 4'b1010, 4'b1111, 4'b0110};
    bit dirs [4] = '{0, 1, 0, 1};
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(!host_nmi && slave_sel == 0, "R11 nmi/sel", {host_nmi, slave_sel}, 0);
    check(slave_rw == 1, "R11 rw", slave_rw, 1);
    check(ctrl_rdata == 0, "R11 ctrl", ctrl_rdata, 0);
    @(negedge clk); rst_n = 1;

    // Sweep of divider and enable/direction patterns: R2 R3 R4 R5 R6 R7
    for (int n = 1; n < 8; n++) begin
      for (int c = 0; c < 4; c++) begin
        logic rw_before;
        int h;
        h = 1 << (n - 1);
        rw_before = slave_rw;
        wr_ctrl({3'b000, ~rw_before, 4'b1111});
        check(!host_nmi && slave_sel == 0, "R7 halt clears", {host_nmi, slave_sel}, 0);
        check(slave_rw == rw_before, "R7 rw kept", slave_rw, rw_before);
        step();
        wr_ctrl({n[2:0], dirs[c], ens[c]});
        check(ctrl_rdata == {n[2:0], dirs[c], ens[c]}, "R1 readback",
              ctrl_rdata, {n[2:0], dirs[c], ens[c]});
        check(!host_nmi, "R3 idle before first event", host_nmi, 0);
        for (int j = 1; j <= 4 * (1 << n); j++) begin
          int k;
          bit act, en;
          step();
          k = (j - 1) / h;
          act = (k % 2 == 0);
          en = act && !(dirs[c] && k == 0);
          check(host_nmi == en, "R2/R3/R6 nmi pattern", host_nmi, en);
          check(slave_sel == (act ? ens[c] : 4'b0), "R4 select",
                slave_sel, act ? ens[c] : 4'b0);
          check(slave_rw == dirs[c], "R5 rw", slave_rw, dirs[c]);
        end
      end
    end

    // R8: restart in write mode while the interrupt is high, n = 2
    wr_ctrl(8'h00); step();
    wr_ctrl({3'd2, 1'b0, 4'b0011});
    wait_nmi_high();
    wr_ctrl({3'd2, 1'b0, 4'b0011});
    for (int j = 1; j <= 8; j++) begin
      bit e;
      step();
      e = (j < 5) || (j >= 7);
      check(host_nmi == e, "R8 extra period", host_nmi, e);
    end

    // R6 with R8: read-mode restart while high, n = 3
    wait_nmi_high();
    wr_ctrl({3'd3, 1'b1, 4'b0100});
    check(!host_nmi, "R6 cleared on write", host_nmi, 0);
    for (int j = 1; j <= 16; j++) begin
      bit e;
      step();
      e = (j >= 13);
      check(host_nmi == e, "R6/R8 suppressed then delayed", host_nmi, e);
      if (j == 13) check(slave_rw == 1, "R5 rw at active", slave_rw, 1);
    end

    // R9 R10: write gating and read mux, all enables and both directions
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] exp_s;
        wr_ctrl({3'd0, d[0], e[3:0]});
        @(negedge clk); data_we = 1; data_wdata = 8'(e * 17 + d);
        #1;
        exp_s = d[0] ? 4'b0 : e[3:0];
        check(slave_wstrobe == exp_s, "R9 strobe gating", slave_wstrobe, exp_s);
        check(slave_wdata == 8'(e * 17 + d), "R9 data", slave_wdata, 8'(e * 17 + d));
        check(data_rdata == or_sel(e[3:0]), "R10 read or", data_rdata, or_sel(e[3:0]));
        @(negedge clk); data_we = 0;
      end
    end

    // R9: data and control write in the same cycle use the old control
    wr_ctrl({3'd0, 1'b0, 4'b1100});
    @(negedge clk); data_we = 1; ctrl_we = 1; ctrl_wdata = {3'd0, 1'b1, 4'b0011};
    #1;
    check(slave_wstrobe == 4'b1100, "R9 same-cycle old control", slave_wstrobe, 4'b1100);
    @(negedge clk); ctrl_we = 0;
    #1;
    check(slave_wstrobe == 4'b0000, "R9 read mode after", slave_wstrobe, 0);
    @(negedge clk); data_we = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule